// File: doc/BRIEF.md
# Interlaced Raster Sync Generator

This block produces the horizontal sync, vertical sync, data-enable and field signals for an interlaced video raster such as 1080i at 60 Hz. It runs in a single pixel-clock domain. A frame is made of two alternating fields. The second field is one line longer than the first. Its vertical sync is shifted by exactly half a line total relative to the horizontal sync that precedes it.

The timing geometry arrives on static input ports and is captured only while reset is held. For 1080i the settings are:

- Horizontal: 1920 active, 88 front porch, 44 sync and 148 back porch clocks.
- Vertical, per field: 540 active lines, 2 front porch lines, 5 sync lines and 15 back-porch lines. The second field adds one back-porch line.

Every output is registered from the same counter state, so every output edge has the same latency. The current pixel and line positions are exported alongside the syncs.

The alignment of the vertical sync is exact:

- In the first field, the VSYNC leading edge lands on the same clock as the HSYNC leading edge.
- In the second field, it lands exactly Htotal/2 clocks later, crossing into the next line when needed.

Top module: `interlaced_sync_gen`

## Requirements
- R1: Every line lasts hTotal = cfgHActive+cfgHFront+cfgHSync+cfgHBack clocks, including the last line of each field. `hsyncOut` is high exactly while `pixelOut` lies in [cfgHActive+cfgHFront, cfgHActive+cfgHFront+cfgHSync).
- R2: Line 0 of each field is its first vertical blanking line. The first field (flag 0) has cfgVFront+cfgVSync+cfgVBack+cfgVActive lines. The second field (flag 1) has one line more. The two fields alternate.
- R3: In the first field, the `vsyncOut` rising edge occurs on the same clock as an `hsyncOut` rising edge. This is an offset of 0, on line cfgVFront.
- R4: In the second field, the `vsyncOut` rising edge occurs exactly hTotal/2 clocks after the most recent `hsyncOut` rising edge. It never coincides with one.
- R5: `vsyncOut` stays high for exactly cfgVSync*hTotal clocks in both fields.
- R6: `fieldOut` is 0 for the first field and 1 for the second. It changes only on the first clock of a field, when `pixelOut`=0 and `lineOut`=0.
- R7: `deOut` is high exactly when `pixelOut` < cfgHActive and `lineOut` >= cfgVFront+cfgVSync+cfgVBack+`fieldOut`.
- R8: `pixelOut` and `lineOut` have the same latency as the syncs. At every `hsyncOut` rising edge, `pixelOut` equals cfgHActive+cfgHFront.
- R9: The configuration inputs are sampled only while `rst` is high. Changing them afterwards has no effect on the outputs.
- R10: While in reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high; captures configuration |
| cfgHActive | input | H_BITS | Active pixels per line |
| cfgHFront | input | H_BITS | Horizontal front porch clocks |
| cfgHSync | input | H_BITS | Horizontal sync width in clocks |
| cfgHBack | input | H_BITS | Horizontal back porch clocks |
| cfgVActive | input | V_BITS | Active lines per field |
| cfgVFront | input | V_BITS | Vertical front porch lines |
| cfgVSync | input | V_BITS | Vertical sync width in lines |
| cfgVBack | input | V_BITS | Back porch lines of the first field |
| hsyncOut | output | 1 | Horizontal sync, active high |
| vsyncOut | output | 1 | Vertical sync, active high |
| deOut | output | 1 | Data enable |
| fieldOut | output | 1 | Field flag (0 first, 1 second) |
| pixelOut | output | H_BITS | Current pixel column |
| lineOut | output | V_BITS | Current line within the field |

## Verification
The embedded assertions check every cycle that:

- the pixel counter advances by one up to the line end;
- fields wrap only at their last line, with the field index toggling there;
- a first-field VSYNC rise coincides with an HSYNC rise, and a second-field VSYNC rise never does;
- the field flag moves only at position zero;
- data enable never overlaps either sync.

Only the bench's scenarios can show the following:

- the exact 0 and Htotal/2 offsets;
- the VSYNC width and the per-field lengths in clocks;
- the full-length lines;
- insensitivity to configuration changes after reset.

The bench runs two geometries, one where the shifted VSYNC edge wraps into the next line and one where it does not.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
  typedef struct packed {
    logic hsOn;
    logic hsOff;
    logic vsOn;
    logic vsOff;
    logic active;
    logic field;
  } syncStrobes_t;
endpackage

// File: rtl/ilace_ctrl.sv
module ilace_ctrl
  import ilace_pkg::*;
#(
  parameter int H_BITS = 12,
  parameter int V_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_BITS-1:0] cfgHActive,
  input  logic [H_BITS-1:0] cfgHFront,
  input  logic [H_BITS-1:0] cfgHSync,
  input  logic [H_BITS-1:0] cfgHBack,
  input  logic [V_BITS-1:0] cfgVActive,
  input  logic [V_BITS-1:0] cfgVFront,
  input  logic [V_BITS-1:0] cfgVSync,
  input  logic [V_BITS-1:0] cfgVBack,
  output syncStrobes_t      strobes,
  output logic [H_BITS-1:0] hCnt,
  output logic [V_BITS-1:0] vCnt
);
  localparam int HT_W = H_BITS + 2;

  // captured geometry
  logic [H_BITS-1:0] hActR, hSyncOnR, hSyncOffR, hLastR, f2ColR;
  logic              f2AddR;
  logic [V_BITS-1:0] vSyncOnR, vSyncOffR, vBlankR, vLast0R;
  logic              fieldIdx;

  // derived values of the raw inputs, used only while in reset
  logic [HT_W-1:0]   hOnW, hTotW, tgtW, colW;
  logic              wrapW;
  logic [V_BITS-1:0] vBlankW;

  always_comb begin
    hOnW    = HT_W'(cfgHActive) + HT_W'(cfgHFront);
    hTotW   = hOnW + HT_W'(cfgHSync) + HT_W'(cfgHBack);
    tgtW    = hOnW + (hTotW >> 1);
    wrapW   = (tgtW >= hTotW);
    colW    = wrapW ? (tgtW - hTotW) : tgtW;
    vBlankW = cfgVFront + cfgVSync + cfgVBack;
  end

  // field-dependent selections
  logic [H_BITS-1:0] colSel;
  logic [V_BITS-1:0] addSel, vLast, vBlank;

  always_comb begin
    colSel = fieldIdx ? f2ColR : hSyncOnR;
    addSel = V_BITS'(fieldIdx & f2AddR);
    vLast  = vLast0R + V_BITS'(fieldIdx);
    vBlank = vBlankR + V_BITS'(fieldIdx);
    strobes.hsOn   = (hCnt == hSyncOnR);
    strobes.hsOff  = (hCnt == hSyncOffR);
    strobes.vsOn   = (hCnt == colSel) && (vCnt == vSyncOnR + addSel);
    strobes.vsOff  = (hCnt == colSel) && (vCnt == vSyncOffR + addSel);
    strobes.active = (hCnt < hActR) && (vCnt >= vBlank);
    strobes.field  = fieldIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hActR     <= cfgHActive;
      hSyncOnR  <= H_BITS'(hOnW);
      hSyncOffR <= H_BITS'(hOnW + HT_W'(cfgHSync));
      hLastR    <= H_BITS'(hTotW - 1'b1);
      f2ColR    <= H_BITS'(colW);
      f2AddR    <= wrapW;
      vSyncOnR  <= cfgVFront;
      vSyncOffR <= cfgVFront + cfgVSync;
      vBlankR   <= vBlankW;
      vLast0R   <= vBlankW + cfgVActive - 1'b1;
      hCnt      <= '0;
      vCnt      <= '0;
      fieldIdx  <= 1'b0;
    end else if (hCnt == hLastR) begin
      hCnt <= '0;
      if (vCnt == vLast) begin
        vCnt     <= '0;
        fieldIdx <= ~fieldIdx;
      end else begin
        vCnt <= vCnt + 1'b1;
      end
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  assert_line_full_R1: assert property (@(posedge clk) disable iff (rst)
    (hCnt != hLastR) |=> (hCnt == $past(hCnt) + 1'b1));

  assert_field_len_R2: assert property (@(posedge clk) disable iff (rst)
    (hCnt == hLastR && vCnt != vLast) |=> (hCnt == '0 && vCnt == $past(vCnt) + 1'b1));

  assert_field_alt_R6: assert property (@(posedge clk) disable iff (rst)
    (hCnt == hLastR && vCnt == vLast) |=> (vCnt == '0 && fieldIdx != $past(fieldIdx)));
endmodule

// File: rtl/ilace_dp.sv
module ilace_dp
  import ilace_pkg::*;
#(
  parameter int H_BITS = 12,
  parameter int V_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  syncStrobes_t      strobes,
  input  logic [H_BITS-1:0] hCnt,
  input  logic [V_BITS-1:0] vCnt,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              fieldOut,
  output logic [H_BITS-1:0] pixelOut,
  output logic [V_BITS-1:0] lineOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      deOut    <= 1'b0;
      fieldOut <= 1'b0;
      pixelOut <= '0;
      lineOut  <= '0;
    end else begin
      if (strobes.hsOn)       hsyncOut <= 1'b1;
      else if (strobes.hsOff) hsyncOut <= 1'b0;
      if (strobes.vsOn)       vsyncOut <= 1'b1;
      else if (strobes.vsOff) vsyncOut <= 1'b0;
      deOut    <= strobes.active;
      fieldOut <= strobes.field;
      pixelOut <= hCnt;
      lineOut  <= vCnt;
    end
  end

  assert_vs_align_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsyncOut) && !fieldOut) |-> $rose(hsyncOut));

  assert_vs_half_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsyncOut) && fieldOut) |-> !$rose(hsyncOut));

  assert_field_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (fieldOut != $past(fieldOut)) |-> (pixelOut == '0 && lineOut == '0));

  assert_de_blank_R7: assert property (@(posedge clk) disable iff (rst)
    deOut |-> (!hsyncOut && !vsyncOut));
endmodule

// File: rtl/interlaced_sync_gen.sv
module interlaced_sync_gen
  import ilace_pkg::*;
#(
  parameter int H_BITS = 12,
  parameter int V_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_BITS-1:0] cfgHActive,
  input  logic [H_BITS-1:0] cfgHFront,
  input  logic [H_BITS-1:0] cfgHSync,
  input  logic [H_BITS-1:0] cfgHBack,
  input  logic [V_BITS-1:0] cfgVActive,
  input  logic [V_BITS-1:0] cfgVFront,
  input  logic [V_BITS-1:0] cfgVSync,
  input  logic [V_BITS-1:0] cfgVBack,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              fieldOut,
  output logic [H_BITS-1:0] pixelOut,
  output logic [V_BITS-1:0] lineOut
);
  syncStrobes_t      strobes;
  logic [H_BITS-1:0] hCnt;
  logic [V_BITS-1:0] vCnt;

  ilace_ctrl #(.H_BITS(H_BITS), .V_BITS(V_BITS)) uCtrl (
    .clk(clk), .rst(rst),
    .cfgHActive(cfgHActive), .cfgHFront(cfgHFront),
    .cfgHSync(cfgHSync), .cfgHBack(cfgHBack),
    .cfgVActive(cfgVActive), .cfgVFront(cfgVFront),
    .cfgVSync(cfgVSync), .cfgVBack(cfgVBack),
    .strobes(strobes), .hCnt(hCnt), .vCnt(vCnt)
  );

  ilace_dp #(.H_BITS(H_BITS), .V_BITS(V_BITS)) uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .hCnt(hCnt), .vCnt(vCnt),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .fieldOut(fieldOut), .pixelOut(pixelOut), .lineOut(lineOut)
  );
endmodule

// File: tb/sim_interlaced_sync_gen.sv
module sim_interlaced_sync_gen;
  localparam int HB = 12;
  localparam int VB = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HB-1:0] cfgHActive, cfgHFront, cfgHSync, cfgHBack;
  logic [VB-1:0] cfgVActive, cfgVFront, cfgVSync, cfgVBack;
  logic hsyncOut, vsyncOut, deOut, fieldOut;
  logic [HB-1:0] pixelOut;
  logic [VB-1:0] lineOut;

  always #4 clk = ~clk;

  interlaced_sync_gen #(.H_BITS(HB), .V_BITS(VB)) u0 (.*);

  typedef struct {
    int    kind;
    int    val;
    string req;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // expected geometry of the active run
  int eHA, eHF, eHS, eHB, eVA, eVF, eVS, eVB;

  function automatic int hTot();
    return eHA + eHF + eHS + eHB;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void scoreboard(input int kind, input int val);
    exp_t it;
    if (expQ.size() == 0) return;
    it = expQ.pop_front();
    checks++;
    if (it.kind != kind || it.val != val) begin
      errors++;
      $display("FAIL %s actual=%0d/%0d expected=%0d/%0d (kind/value)",
               it.req, kind, val, it.kind, it.val);
    end
  endfunction

  task automatic setCfg(input int ha, hf, hs, hb, va, vf, vs, vb);
    cfgHActive = HB'(ha); cfgHFront = HB'(hf); cfgHSync = HB'(hs); cfgHBack = HB'(hb);
    cfgVActive = VB'(va); cfgVFront = VB'(vf); cfgVSync = VB'(vs); cfgVBack = VB'(vb);
  endtask

  // driver: expected per-field events, in the order they occur
  task automatic pushFields(input int n);
    for (int i = 0; i < n; i++) begin
      int f;
      int lines;
      exp_t it;
      f = i % 2;
      lines = eVF + eVS + eVB + eVA + f;
      it.kind = 0; it.val = f ? hTot() / 2 : 0; it.req = f ? "R4 vsync offset" : "R3 vsync offset";
      expQ.push_back(it);
      it.kind = 1; it.val = eVS * hTot(); it.req = "R5 vsync width";
      expQ.push_back(it);
      it.kind = 2; it.val = lines * hTot(); it.req = "R2 field length";
      expQ.push_back(it);
      it.kind = 3; it.val = 1 - f; it.req = "R6 field flag";
      expQ.push_back(it);
    end
  endtask

  task automatic waitDrain(input int limit);
    int t;
    t = 0;
    while (expQ.size() != 0 && t < limit) begin
      @(posedge clk);
      t++;
    end
    check(expQ.size() == 0, "R2 expected events not all seen", expQ.size(), 0);
    expQ.delete();
  endtask

  // monitor
  int since = 0;
  int lastHs, vsRise, fieldStart;
  bit prevHs, prevVs, prevField;

  always @(negedge clk) begin
    cyc++;
    if (rst) since = 0;
    else if (since < 3) since++;
    if (since == 2) begin
      fieldStart = cyc;
      lastHs = -1;
      vsRise = cyc;
    end
    if (since >= 2 && !finished) begin
      begin : levelChecks
        int p, l, hsOnCol;
        bit deExp, hsExp;
        p = int'(pixelOut);
        l = int'(lineOut);
        hsOnCol = eHA + eHF;
        deExp = (p < eHA) && (l >= eVF + eVS + eVB + int'(fieldOut));
        hsExp = (p >= hsOnCol) && (p < hsOnCol + eHS);
        check(deOut == deExp, "R7 data enable", deOut, deExp);
        check(hsyncOut == hsExp, "R1 hsync level", hsyncOut, hsExp);
        if (hsyncOut && !prevHs) begin
          check(p == hsOnCol, "R8 pixel at hsync rise", p, hsOnCol);
          if (lastHs >= 0)
            check(cyc - lastHs == hTot(), "R1 line length", cyc - lastHs, hTot());
          lastHs = cyc;
        end
      end
      if (vsyncOut && !prevVs) begin
        vsRise = cyc;
        scoreboard(0, cyc - lastHs);
      end
      if (!vsyncOut && prevVs) scoreboard(1, cyc - vsRise);
      if (fieldOut != prevField) begin
        scoreboard(2, cyc - fieldStart);
        scoreboard(3, int'(fieldOut));
        fieldStart = cyc;
      end
    end
    prevHs = hsyncOut;
    prevVs = vsyncOut;
    prevField = fieldOut;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // geometry A: shifted vsync edge wraps into the next line (28 clocks, col 20 + 14)
    eHA = 16; eHF = 4; eHS = 3; eHB = 5; eVA = 4; eVF = 1; eVS = 2; eVB = 2;
    setCfg(eHA, eHF, eHS, eHB, eVA, eVF, eVS, eVB);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check({hsyncOut, vsyncOut, deOut, fieldOut} == 4'b0, "R10 reset syncs",
          {hsyncOut, vsyncOut, deOut, fieldOut}, 0);
    check(pixelOut == 0 && lineOut == 0, "R10 reset counters", int'(pixelOut) + int'(lineOut), 0);
    pushFields(4);
    @(posedge clk); #1;
    rst = 1'b0;
    // R9: inputs changed after reset must not matter
    @(posedge clk); #1;
    setCfg(8, 2, 4, 30, 3, 2, 3, 1);
    waitDrain(5000);

    // geometry B: shifted edge stays within the line (44 clocks, col 10 + 22)
    @(posedge clk); #1;
    rst = 1'b1;
    eHA = 8; eHF = 2; eHS = 4; eHB = 30; eVA = 3; eVF = 2; eVS = 3; eVB = 1;
    setCfg(eHA, eHF, eHS, eHB, eVA, eVF, eVS, eVB);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({hsyncOut, vsyncOut, deOut, fieldOut} == 4'b0, "R10 reset after run",
          {hsyncOut, vsyncOut, deOut, fieldOut}, 0);
    pushFields(4);
    @(posedge clk); #1;
    rst = 1'b0;
    waitDrain(5000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule